// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a running BCD calendar and raises an alarm when the time of day and the day match a programmable 32-bit alarm word. The comparison is made only on the tick that advances the calendar. A mask bit per field can remove seconds, minutes, hours or the day from the match. The day field compares either the day of the month or the weekday, chosen by a selector bit.

A match sets a sticky flag, and software clears that flag by a write. The interrupt line is the flag gated by an interrupt-enable bit. The alarm word is protected. Software must first clear the alarm enable, then wait until the write-allowed indication comes up, then write the new word, and finally enable the alarm again. Any write to the alarm word made while the indication is low is dropped.

Top module: `alarm_cmp`

## Requirements
- R1: While reset is asserted and right after it, the flag, interrupt, write-allowed indication and alarm word are all 0, and the alarm and interrupt enables are off.
- R2: Time fields in the alarm word are compared with the current inputs as follows. Seconds sit in bits 6:0, minutes in bits 14:8, and hours in bits 21:16 together with a PM bit 22 that must equal the PM input. A set bit 7, 15 or 23 removes seconds, minutes or hours from the comparison.
- R3: When bit 30 is 0, bits 29:24 are compared with the date input. When bit 30 is 1, bits 27:24 are compared with the zero-extended weekday input. A set bit 31 removes the day from the comparison.
- R4: The flag is set only on a cycle with the tick high, the alarm enable (control bit 8) on, and every unmasked field matching. A matching calendar without a tick, or a tick while the alarm is disabled, leaves the flag clear.
- R5: The flag stays set until a status write (select 1) with bit 8 equal to 0 clears it. A status write with bit 8 equal to 1 has no effect. If a clear and a new match fall in the same cycle, the flag stays set.
- R6: The interrupt output equals the flag ANDed with the interrupt enable (control bit 12).
- R7: The write-allowed output goes high WAIT_CYC clock edges after the alarm enable is cleared, counting the edge of the clearing write. It goes low on the edge that sets the enable.
- R8: A write with select 2 loads the alarm word only while the write-allowed output is high. Otherwise the word is unchanged. Select 0 writes control and select 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Calendar-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Strobe for the cycle in which the calendar advances |
| cur_sec_i | input | 7 | Current seconds, BCD |
| cur_min_i | input | 7 | Current minutes, BCD |
| cur_hour_i | input | 6 | Current hours, BCD |
| cur_pm_i | input | 1 | Current PM indication |
| cur_date_i | input | 6 | Current day of month, BCD |
| cur_wday_i | input | 3 | Current weekday, 1 to 7 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 control, 1 status, 2 alarm word, 3 none |
| wr_data_i | input | 32 | Write data |
| flag_o | output | 1 | Sticky alarm flag |
| irq_o | output | 1 | Alarm interrupt |
| wr_ok_o | output | 1 | Alarm word may be written |
| word_o | output | 32 | Current alarm word |

## Verification
The bench builds the block with WAIT_CYC at its default of 2. This makes the rise of the write-allowed output land on an exact, countable edge after each disable, so both a locked write and an accepted write can be placed precisely. A behavioural model runs next to the design and is compared on every clock. Directed sequences then cover:
- each field mask,
- the PM bit,
- weekday against date selection,
- a match without a tick,
- a match while the alarm is disabled,
- a clear that arrives in the same cycle as a match.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
    localparam int WORD_W   = 32;
    localparam int EN_BIT   = 8;
    localparam int IE_BIT   = 12;
    localparam int FLAG_BIT = 8;
    localparam int NUM_TF   = 3;   // seconds, minutes, hours+PM
    localparam int TF_W     = 7;
    localparam int DAY_SEL  = 30;
    localparam int DAY_MSK  = 31;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_WORD = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic       pm;
        logic [5:0] date;
        logic [2:0] wday;
    } cal_t;

    typedef struct packed {
        logic              en;
        logic              ie;
        logic              flag;
        logic [WORD_W-1:0] word;
    } alm_state_t;
endpackage

// File: rtl/alarm_field_match.sv
module alarm_field_match
    import alarm_cmp_pkg::*;
(
    input  cal_t              cal_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              hit_o
);
    localparam int FIELD_STRIDE = 8;

    logic [NUM_TF-1:0][TF_W-1:0] cur_f;
    logic [NUM_TF-1:0]           tf_hit;
    logic                        day_hit;

    assign cur_f[0] = cal_i.sec;
    assign cur_f[1] = cal_i.min;
    assign cur_f[2] = {cal_i.pm, cal_i.hour};

    for (genvar g = 0; g < NUM_TF; g++) begin : g_tf
        localparam int LO = g * FIELD_STRIDE;
        assign tf_hit[g] = word_i[LO + TF_W] || (word_i[LO +: TF_W] == cur_f[g]);
    end

    always_comb begin
        if (word_i[DAY_MSK]) begin
            day_hit = 1'b1;
        end else if (word_i[DAY_SEL]) begin
            day_hit = (word_i[27:24] == {1'b0, cal_i.wday});
        end else begin
            day_hit = (word_i[29:24] == cal_i.date);
        end
    end

    assign hit_o = (&tf_hit) && day_hit;
endmodule

// File: rtl/alarm_wr_gate.sv
module alarm_wr_gate #(
    parameter int WAIT_CYC = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_next_i,
    output logic wr_ok_o
);
    localparam int CNT_W = $clog2(WAIT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WAIT_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (en_next_i) begin
            cnt_d = '0;
        end else if (cnt_q == CNT_MAX) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign wr_ok_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
    import alarm_cmp_pkg::*;
#(
    parameter int WAIT_CYC = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [6:0]        cur_sec_i,
    input  logic [6:0]        cur_min_i,
    input  logic [5:0]        cur_hour_i,
    input  logic              cur_pm_i,
    input  logic [5:0]        cur_date_i,
    input  logic [2:0]        cur_wday_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic              flag_o,
    output logic              irq_o,
    output logic              wr_ok_o,
    output logic [WORD_W-1:0] word_o
);
    alm_state_t st_d, st_q;
    cal_t       cal;
    logic       hit;
    logic       alm_en;
    reg_sel_e   sel;

    assign cal = '{sec: cur_sec_i, min: cur_min_i, hour: cur_hour_i,
                   pm: cur_pm_i, date: cur_date_i, wday: cur_wday_i};
    assign sel = reg_sel_e'(wr_sel_i);

    alarm_field_match u_match (
        .cal_i  (cal),
        .word_i (st_q.word),
        .hit_o  (hit)
    );

    alarm_wr_gate #(.WAIT_CYC(WAIT_CYC)) u_gate (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_next_i (st_d.en),
        .wr_ok_o   (wr_ok_o)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            unique case (sel)
                SEL_CTRL: begin
                    st_d.en = wr_data_i[EN_BIT];
                    st_d.ie = wr_data_i[IE_BIT];
                end
                SEL_STAT: begin
                    if (!wr_data_i[FLAG_BIT]) st_d.flag = 1'b0;
                end
                SEL_WORD: begin
                    if (wr_ok_o) st_d.word = wr_data_i;
                end
                default: ;
            endcase
        end
        // a fresh event outranks a clear in the same cycle
        if (tick_i && st_q.en && hit) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alm_en = st_q.en;
    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag && st_q.ie;
    assign word_o = st_q.word;
endmodule

// File: rtl/alarm_cmp_chk.sv
module alarm_cmp_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic [31:0] wr_data,
    input logic        en,
    input logic        flag,
    input logic        irq,
    input logic        wr_ok,
    input logic [31:0] word
);
    // R4
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(tick) && $past(en)));

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_en && wr_sel == 2'd1 && !wr_data[8])) |=> flag);

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    // R7
    wr_ok_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_ok) |-> !$past(en));

    // R7
    wr_ok_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> !wr_ok);

    // R8
    word_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(word));
endmodule

bind alarm_cmp alarm_cmp_chk u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .tick    (tick_i),
    .wr_en   (wr_en_i),
    .wr_sel  (wr_sel_i),
    .wr_data (wr_data_i),
    .en      (alm_en),
    .flag    (flag_o),
    .irq     (irq_o),
    .wr_ok   (wr_ok_o),
    .word    (word_o)
);

// File: tb/alarm_cmp_tb.sv
module alarm_cmp_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WAITC      = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [6:0]  sec = '0, mn = '0;
    logic [5:0]  hr = '0, date = '0;
    logic        pm = 1'b0;
    logic [2:0]  wday = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        flag, irq, wr_ok;
    logic [31:0] word;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    bit      m_en, m_ie, m_flag;
    bit [31:0] m_word;
    int      m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_cmp #(.WAIT_CYC(WAITC)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
        .cur_sec_i(sec), .cur_min_i(mn), .cur_hour_i(hr), .cur_pm_i(pm),
        .cur_date_i(date), .cur_wday_i(wday),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .flag_o(flag), .irq_o(irq), .wr_ok_o(wr_ok), .word_o(word)
    );

    function automatic bit ref_hit(bit [31:0] w);
        bit s, m, h, d;
        s = w[7]  || (w[6:0] == sec);
        m = w[15] || (w[14:8] == mn);
        h = w[23] || ((w[21:16] == hr) && (w[22] == pm));
        if (w[31]) d = 1;
        else if (w[30]) d = (int'(w[27:24]) == int'(wday));
        else d = (w[29:24] == date);
        return s && m && h && d;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_ie = 0; m_flag = 0; m_word = '0; m_cnt = 0;
        end else begin
            bit n_en, n_ie, n_flag, ok_now;
            bit [31:0] n_word;
            ok_now = (m_cnt == WAITC);
            n_en = m_en; n_ie = m_ie; n_flag = m_flag; n_word = m_word;
            if (wr_en && wr_sel == 2'd0) begin n_en = wr_data[8]; n_ie = wr_data[12]; end
            if (wr_en && wr_sel == 2'd1 && !wr_data[8]) n_flag = 0;
            if (wr_en && wr_sel == 2'd2 && ok_now) n_word = wr_data;
            if (tick && m_en && ref_hit(m_word)) n_flag = 1;
            if (n_en) m_cnt = 0;
            else if (m_cnt < WAITC) m_cnt = m_cnt + 1;
            m_en = n_en; m_ie = n_ie; m_flag = n_flag; m_word = n_word;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_model();
        chk("R5 flag vs model", {31'b0, flag}, {31'b0, m_flag});
        chk("R6 irq vs model", {31'b0, irq}, {31'b0, m_flag && m_ie});
        chk("R7 wr_ok vs model", {31'b0, wr_ok}, {31'b0, m_cnt == WAITC});
        chk("R8 word vs model", word, m_word);
    endtask

    task automatic cyc();
        @(negedge clk);
        cmp_model();
    endtask

    task automatic wr(logic [1:0] s, logic [31:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        cyc();
        wr_en = 0; wr_sel = 2'd3; wr_data = '0;
    endtask

    task automatic tk();
        tick = 1;
        cyc();
        tick = 0;
    endtask

    // disable, wait for write permission, load word, enable with ie
    task automatic reload(logic [31:0] w);
        wr(2'd1, 32'h0);
        wr(2'd0, 32'h0);
        cyc();
        wr(2'd2, w);
        wr(2'd0, 32'h1100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wr_sel = 2'd3;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 flag", {31'b0, flag}, 32'd0);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 wr_ok", {31'b0, wr_ok}, 32'd0);
        chk("R1 word", word, 32'd0);
        rst_n = 1;
        cyc(); chk("R7 wr_ok after 1 edge", {31'b0, wr_ok}, 32'd0);
        cyc(); chk("R7 wr_ok after 2 edges", {31'b0, wr_ok}, 32'd1);

        wr(2'd2, 32'h8080_8030);
        chk("R8 word accepted", word, 32'h8080_8030);
        wr(2'd0, 32'h1100);
        chk("R7 wr_ok drops on enable", {31'b0, wr_ok}, 32'd0);
        wr(2'd2, 32'h1234_5678);
        chk("R8 locked write dropped", word, 32'h8080_8030);
        wr(2'd3, 32'hFFFF_FFFF);
        chk("R8 select 3 ignored", word, 32'h8080_8030);

        sec = 7'h30; cyc();
        chk("R4 no tick no flag", {31'b0, flag}, 32'd0);
        sec = 7'h29; tk();
        chk("R2 seconds mismatch", {31'b0, flag}, 32'd0);
        sec = 7'h30; tk();
        chk("R4 match sets flag", {31'b0, flag}, 32'd1);
        chk("R6 irq with ie", {31'b0, irq}, 32'd1);

        wr(2'd1, 32'h100);
        chk("R5 write one no effect", {31'b0, flag}, 32'd1);
        wr(2'd1, 32'h0);
        chk("R5 clear", {31'b0, flag}, 32'd0);
        wr_en = 1; wr_sel = 2'd1; wr_data = 32'h0; tick = 1;
        cyc();
        wr_en = 0; wr_sel = 2'd3; tick = 0;
        chk("R5 set beats clear", {31'b0, flag}, 32'd1);
        wr(2'd0, 32'h100);
        chk("R6 irq off without ie", {31'b0, irq}, 32'd0);
        chk("R6 flag kept", {31'b0, flag}, 32'd1);

        wr(2'd1, 32'h0);
        wr(2'd0, 32'h0);
        chk("R7 wr_ok one edge after disable", {31'b0, wr_ok}, 32'd0);
        cyc();
        chk("R7 wr_ok two edges after disable", {31'b0, wr_ok}, 32'd1);
        tk();
        chk("R4 disabled no flag", {31'b0, flag}, 32'd0);

        wr(2'd2, 32'h8051_4500);
        wr(2'd0, 32'h1100);
        sec = 7'h00; mn = 7'h45; hr = 6'h11; pm = 0; tk();
        chk("R2 PM mismatch", {31'b0, flag}, 32'd0);
        pm = 1; tk();
        chk("R2 hour/min/sec/PM match", {31'b0, flag}, 32'd1);
        mn = 7'h44; wr(2'd1, 32'h0); tk();
        chk("R2 minute mismatch", {31'b0, flag}, 32'd0);

        reload(32'h4380_8080);
        wday = 3'd4; date = 6'h03; tk();
        chk("R3 weekday mismatch", {31'b0, flag}, 32'd0);
        wday = 3'd3; tk();
        chk("R3 weekday match", {31'b0, flag}, 32'd1);

        reload(32'h1580_8080);
        date = 6'h16; tk();
        chk("R3 date mismatch", {31'b0, flag}, 32'd0);
        date = 6'h15; tk();
        chk("R3 date match", {31'b0, flag}, 32'd1);

        reload(32'h9580_8080);
        date = 6'h02; wday = 3'd7; tk();
        chk("R3 day masked", {31'b0, flag}, 32'd1);

        cyc();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule